// File: doc/BRIEF.md
# Frame-Local Scratchpad Spill/Fill Store

This block is a small byte-addressed local memory that keeps long-lived values after they have dropped off the operand belt. Each function invocation owns a private region of the store. A region is empty at entry and must be sized by an explicit allocate request before any access. Spill requests write a 1, 2, 4 or 8 byte operand at a static byte offset inside the current region. Fill requests read an operand back and return it, zero-extended, with a valid strobe.

Regions are stacked. A call strobe saves the current region's base and size and opens a new region directly above it. The new region starts with size zero. A return strobe discards the callee region and restores the caller's region with its data untouched. A request that is misaligned, lies outside the allocated size or breaks the stack limits raises a one-cycle fault. Such a request changes neither the memory nor the frame state.

Spills go through a short write pipeline, so a fill picks up a spilled value only when it is issued three or more cycles after the spill. A fill issued earlier returns the older contents. Fill results appear exactly two cycles after the request.

Top module: `sp_scratchpad`

## Requirements
- R1: After reset the fault and fill-valid outputs are low, the memory reads as zero, the stack is empty and the current region has size zero, so every spill or fill faults until an allocation is made.
- R2: An allocate request of size S succeeds when S is at most MAX_FRAME and the region base plus S is at most MEM_BYTES; otherwise it faults and the region size is unchanged.
- R3: The width code selects the operand size: code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. Byte k of the data goes to region offset off+k, and a fill returns the operand zero-extended to the full data width.
- R4: A spill or fill whose offset is not a multiple of its operand size faults, does not write memory and produces no fill-valid strobe.
- R5: A spill or fill for which offset plus operand size exceeds the current region size faults, with the same absence of effects as R4.
- R6: An accepted fill raises the fill-valid output, with its data, exactly two cycles after the request cycle, and not one cycle after.
- R7: A fill issued three or more cycles after a spill to the same bytes returns the spilled value; a fill issued one or two cycles after it returns the previous contents.
- R8: A call strobe opens a region whose base is the caller's base plus the caller's size, with size zero; when STACK_DEPTH regions are already saved it faults and nothing changes.
- R9: A return strobe restores the caller's base and size, and the caller's spilled data reads back unchanged; with an empty stack it faults and nothing changes.
- R10: When more than one of allocate, call and return is asserted in one cycle, the request faults and none of them takes effect.
- R11: The fault output is high for exactly the cycle after a cycle that holds a faulting request, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocate request for the current region |
| alloc_size | input | SZW | Requested region size in bytes |
| call_push | input | 1 | Open a fresh region for a callee |
| ret_pop | input | 1 | Discard the current region and restore the caller |
| spill_vld | input | 1 | Spill request |
| spill_off | input | OFFW | Spill byte offset within the region |
| spill_wcode | input | 2 | Spill width code (0:1B, 1:2B, 2:4B, 3:8B) |
| spill_data | input | 8*DATA_BYTES | Spill operand, little-endian |
| fill_vld | input | 1 | Fill request |
| fill_off | input | OFFW | Fill byte offset within the region |
| fill_wcode | input | 2 | Fill width code |
| fill_rvld | output | 1 | Fill result valid |
| fill_rdata | output | 8*DATA_BYTES | Fill result, zero-extended |
| fault | output | 1 | One-cycle fault pulse |

## Verification
The assertions take the strobes to be clean after reset and measure every latency from the cycle in which a request is presented. They assume that one request of each kind arrives per cycle and that the offsets fit the offset port. The bench keeps within this by driving each request for a single cycle on the falling edge. It serializes whole spill and fill transactions, except in the directed ordering test that deliberately places fills one and two cycles after a spill. Allocation sizes go above MAX_FRAME only to provoke the R2 fault. The stack is pushed to its limit and popped past empty only to reach the R8 and R9 boundaries.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // Width code to byte count: 0->1, 1->2, 2->4, 3->8.
  function automatic int unsigned wbytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // Offset must be a multiple of the operand size.
  function automatic logic is_aligned(input int unsigned off, input logic [1:0] code);
    return (off & (wbytes(code) - 32'd1)) == 32'd0;
  endfunction

  // Operand must lie entirely inside the allocated region.
  function automatic logic in_region(input int unsigned off, input logic [1:0] code,
                                     input int unsigned size);
    return (off + wbytes(code)) <= size;
  endfunction

  // Write-side stages: a spill reaches memory at the third edge after its request.
  localparam int unsigned WR_STAGES = 2;
  // Read-side stages: fill data is valid two cycles after the request.
  localparam int unsigned RD_STAGES = 2;
endpackage

// File: rtl/sp_frame_ctl.sv
module sp_frame_ctl #(
  parameter int MEM_BYTES   = 64,
  parameter int MAX_FRAME   = 16,
  parameter int STACK_DEPTH = 4,
  parameter int BW  = $clog2(MEM_BYTES + 1),
  parameter int SZW = $clog2(MAX_FRAME + 1),
  parameter int DPW = $clog2(STACK_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_vld,
  input  logic [SZW-1:0] alloc_size,
  input  logic           push,
  input  logic           pop,
  output logic [BW-1:0]  base,
  output logic [SZW-1:0] size,
  output logic [DPW-1:0] depth,
  output logic           ctl_fault,
  output logic           push_ok,
  output logic           pop_ok
);
  localparam int IW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [BW-1:0]  stk_base [STACK_DEPTH];
  logic [SZW-1:0] stk_size [STACK_DEPTH];
  logic           clash, alloc_bad, alloc_ok, full;
  logic [IW-1:0]  wr_idx, rd_idx;

  assign clash     = $countones({alloc_vld, push, pop}) > 1;
  assign alloc_bad = (32'(alloc_size) > MAX_FRAME) ||
                     (32'(base) + 32'(alloc_size) > MEM_BYTES);
  assign full      = 32'(depth) == STACK_DEPTH;
  assign alloc_ok  = alloc_vld && !clash && !alloc_bad;
  assign push_ok   = push && !clash && !full;
  assign pop_ok    = pop && !clash && (depth != '0);
  assign ctl_fault = (alloc_vld || push || pop) && !(alloc_ok || push_ok || pop_ok);
  assign wr_idx    = IW'(depth);
  assign rd_idx    = IW'(depth - DPW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      size  <= '0;
      depth <= '0;
    end else if (alloc_ok) begin
      size <= alloc_size;
    end else if (push_ok) begin
      base  <= base + BW'(size);
      size  <= '0;
      depth <= depth + DPW'(1);
    end else if (pop_ok) begin
      base  <= stk_base[rd_idx];
      size  <= stk_size[rd_idx];
      depth <= depth - DPW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      stk_base[wr_idx] <= base;
      stk_size[wr_idx] <= size;
    end
  end
endmodule

// File: rtl/sp_access_chk.sv
module sp_access_chk import sp_pkg::*; #(
  parameter int OFFW = 4,
  parameter int SZW  = 5
) (
  input  logic            req,
  input  logic [OFFW-1:0] off,
  input  logic [1:0]      code,
  input  logic [SZW-1:0]  size,
  output logic            ok,
  output logic            bad
);
  assign ok  = req && is_aligned(32'(off), code) && in_region(32'(off), code, 32'(size));
  assign bad = req && !ok;
endmodule

// File: rtl/sp_store.sv
module sp_store import sp_pkg::*; #(
  parameter int MEM_BYTES  = 64,
  parameter int DATA_BYTES = 8,
  parameter int BW  = $clog2(MEM_BYTES + 1),
  parameter int DW  = 8 * DATA_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [BW-1:0] wr_addr,
  input  logic [1:0]    wr_code,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic [BW-1:0] rd_addr,
  input  logic [1:0]    rd_code,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data,
  output logic          wr_commit
);
  localparam int MIW = $clog2(MEM_BYTES);

  logic [7:0]    mem [MEM_BYTES];
  logic          wp_vld  [WR_STAGES];
  logic [BW-1:0] wp_addr [WR_STAGES];
  logic [1:0]    wp_code [WR_STAGES];
  logic [DW-1:0] wp_data [WR_STAGES];
  logic          rp_vld  [RD_STAGES];
  logic [DW-1:0] rp_data [RD_STAGES];
  logic [DW-1:0] rd_word;

  assign wr_commit = wp_vld[WR_STAGES-1];

  // Spill delay line, so that memory holds a spill from the third edge onward.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < WR_STAGES; s++) wp_vld[s] <= 1'b0;
    end else begin
      wp_vld[0] <= wr_req;
      for (int s = 1; s < WR_STAGES; s++) wp_vld[s] <= wp_vld[s-1];
    end
  end

  always_ff @(posedge clk) begin
    wp_addr[0] <= wr_addr;
    wp_code[0] <= wr_code;
    wp_data[0] <= wr_data;
    for (int s = 1; s < WR_STAGES; s++) begin
      wp_addr[s] <= wp_addr[s-1];
      wp_code[s] <= wp_code[s-1];
      wp_data[s] <= wp_data[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < MEM_BYTES; b++) mem[b] <= 8'h00;
    end else if (wr_commit) begin
      for (int unsigned i = 0; i < DATA_BYTES; i++) begin
        if (i < wbytes(wp_code[WR_STAGES-1]) &&
            32'(wp_addr[WR_STAGES-1]) + i < MEM_BYTES)
          mem[MIW'(32'(wp_addr[WR_STAGES-1]) + i)] <= wp_data[WR_STAGES-1][8*i +: 8];
      end
    end
  end

  // Gather the operand bytes; bytes above the width read as zero.
  always_comb begin
    rd_word = '0;
    for (int unsigned i = 0; i < DATA_BYTES; i++) begin
      if (i < wbytes(rd_code) && 32'(rd_addr) + i < MEM_BYTES)
        rd_word[8*i +: 8] = mem[MIW'(32'(rd_addr) + i)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < RD_STAGES; s++) rp_vld[s] <= 1'b0;
    end else begin
      rp_vld[0] <= rd_req;
      for (int s = 1; s < RD_STAGES; s++) rp_vld[s] <= rp_vld[s-1];
    end
  end

  always_ff @(posedge clk) begin
    rp_data[0] <= rd_word;
    for (int s = 1; s < RD_STAGES; s++) rp_data[s] <= rp_data[s-1];
  end

  assign rd_vld  = rp_vld[RD_STAGES-1];
  assign rd_data = rp_data[RD_STAGES-1];
endmodule

// File: rtl/sp_scratchpad.sv
module sp_scratchpad #(
  parameter int DATA_BYTES  = 8,
  parameter int MEM_BYTES   = 64,
  parameter int MAX_FRAME   = 16,
  parameter int STACK_DEPTH = 4,
  parameter int SZW  = $clog2(MAX_FRAME + 1),
  parameter int OFFW = $clog2(MAX_FRAME),
  parameter int DW   = 8 * DATA_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_vld,
  input  logic [SZW-1:0]  alloc_size,
  input  logic            call_push,
  input  logic            ret_pop,
  input  logic            spill_vld,
  input  logic [OFFW-1:0] spill_off,
  input  logic [1:0]      spill_wcode,
  input  logic [DW-1:0]   spill_data,
  input  logic            fill_vld,
  input  logic [OFFW-1:0] fill_off,
  input  logic [1:0]      fill_wcode,
  output logic            fill_rvld,
  output logic [DW-1:0]   fill_rdata,
  output logic            fault
);
  localparam int BW  = $clog2(MEM_BYTES + 1);
  localparam int DPW = $clog2(STACK_DEPTH + 1);

  // Named internal events for the checker.
  logic [BW-1:0]  frame_base;
  logic [SZW-1:0] frame_size;
  logic [DPW-1:0] depth;
  logic           ctl_fault, push_ok, pop_ok;
  logic           spill_ok, spill_bad, fill_ok, fill_bad, wr_commit;
  logic [BW-1:0]  spill_addr, fill_addr;

  sp_frame_ctl #(.MEM_BYTES(MEM_BYTES), .MAX_FRAME(MAX_FRAME), .STACK_DEPTH(STACK_DEPTH),
                 .BW(BW), .SZW(SZW), .DPW(DPW)) u_frame (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_size(alloc_size),
    .push(call_push), .pop(ret_pop), .base(frame_base), .size(frame_size),
    .depth(depth), .ctl_fault(ctl_fault), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  sp_access_chk #(.OFFW(OFFW), .SZW(SZW)) u_spill_chk (
    .req(spill_vld), .off(spill_off), .code(spill_wcode), .size(frame_size),
    .ok(spill_ok), .bad(spill_bad)
  );

  sp_access_chk #(.OFFW(OFFW), .SZW(SZW)) u_fill_chk (
    .req(fill_vld), .off(fill_off), .code(fill_wcode), .size(frame_size),
    .ok(fill_ok), .bad(fill_bad)
  );

  assign spill_addr = frame_base + BW'(spill_off);
  assign fill_addr  = frame_base + BW'(fill_off);

  sp_store #(.MEM_BYTES(MEM_BYTES), .DATA_BYTES(DATA_BYTES), .BW(BW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_req(spill_ok), .wr_addr(spill_addr), .wr_code(spill_wcode), .wr_data(spill_data),
    .rd_req(fill_ok), .rd_addr(fill_addr), .rd_code(fill_wcode),
    .rd_vld(fill_rvld), .rd_data(fill_rdata), .wr_commit(wr_commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= ctl_fault || spill_bad || fill_bad;
  end
endmodule

// File: rtl/sp_scratchpad_chk.sv
module sp_scratchpad_chk #(
  parameter int MEM_BYTES = 64,
  parameter int BW  = 7,
  parameter int SZW = 5,
  parameter int DPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           alloc_vld,
  input logic           call_push,
  input logic           ret_pop,
  input logic           fill_rvld,
  input logic           fault,
  input logic [BW-1:0]  frame_base,
  input logic [SZW-1:0] frame_size,
  input logic [DPW-1:0] depth,
  input logic           ctl_fault,
  input logic           push_ok,
  input logic           pop_ok,
  input logic           spill_ok,
  input logic           spill_bad,
  input logic           fill_ok,
  input logic           fill_bad,
  input logic           wr_commit
);
  p_fill_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |-> ##2 fill_rvld);

  p_fill_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bad |-> ##2 !fill_rvld);

  p_fault_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_bad || fill_bad || ctl_fault) |=> fault);

  p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_bad || fill_bad || ctl_fault) |=> !fault);

  p_commit_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(spill_ok, 2));

  p_region_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_base) + 32'(frame_size) <= MEM_BYTES);

  p_push_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (frame_size == '0) &&
                (32'(frame_base) == 32'($past(frame_base)) + 32'($past(frame_size))));

  p_pop_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> 32'(depth) + 32'd1 == 32'($past(depth)));

  p_clash_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({alloc_vld, call_push, ret_pop}) > 1) |=>
      ($stable(frame_base) && $stable(frame_size) && $stable(depth)));
endmodule

bind sp_scratchpad sp_scratchpad_chk #(
  .MEM_BYTES(MEM_BYTES), .BW(BW), .SZW(SZW), .DPW(DPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .call_push(call_push),
  .ret_pop(ret_pop), .fill_rvld(fill_rvld), .fault(fault),
  .frame_base(frame_base), .frame_size(frame_size), .depth(depth),
  .ctl_fault(ctl_fault), .push_ok(push_ok), .pop_ok(pop_ok),
  .spill_ok(spill_ok), .spill_bad(spill_bad), .fill_ok(fill_ok),
  .fill_bad(fill_bad), .wr_commit(wr_commit)
);

// File: tb/sp_scratchpad_tb.sv
`timescale 1ns/1ps
module sp_scratchpad_tb;
  localparam int MEMB = 64;
  localparam int MAXF = 16;
  localparam int SDEP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_vld = 1'b0;
  logic [4:0]  alloc_size = '0;
  logic        call_push = 1'b0, ret_pop = 1'b0;
  logic        spill_vld = 1'b0;
  logic [3:0]  spill_off = '0;
  logic [1:0]  spill_wcode = '0;
  logic [63:0] spill_data = '0;
  logic        fill_vld = 1'b0;
  logic [3:0]  fill_off = '0;
  logic [1:0]  fill_wcode = '0;
  logic        fill_rvld;
  logic [63:0] fill_rdata;
  logic        fault;

  int n_vec = 0, n_err = 0;
  bit done = 0;

  // Reference model state.
  logic [7:0] bm [MEMB];
  int mb = 0, ms = 0, md = 0;
  int sb [SDEP];
  int ss [SDEP];

  always #10 clk = ~clk;

  sp_scratchpad u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_size(alloc_size),
    .call_push(call_push), .ret_pop(ret_pop), .spill_vld(spill_vld),
    .spill_off(spill_off), .spill_wcode(spill_wcode), .spill_data(spill_data),
    .fill_vld(fill_vld), .fill_off(fill_off), .fill_wcode(fill_wcode),
    .fill_rvld(fill_rvld), .fill_rdata(fill_rdata), .fault(fault)
  );

  task automatic chk(input bit good, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!good) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit acc_ok(input int off, input int code);
    int nb = 1 << code;
    return ((off % nb) == 0) && (off + nb <= ms);
  endfunction

  function automatic logic [63:0] model_rd(input int off, input int code);
    logic [63:0] v = '0;
    for (int i = 0; i < (1 << code); i++) v[8*i +: 8] = bm[mb + off + i];
    return v;
  endfunction

  function automatic logic [63:0] pat(input int off, input int code, input int salt);
    return {8{8'(off * 17 + code * 5 + salt * 29 + 3)}} ^ 64'h0F1E2D3C4B5A6978;
  endfunction

  // Spill, check the fault pulse, then idle so the next request is 3 cycles later.
  task automatic do_spill(input int off, input int code, input logic [63:0] d,
                          input string tag);
    bit ok = acc_ok(off, code);
    spill_vld = 1'b1; spill_off = 4'(off); spill_wcode = 2'(code); spill_data = d;
    @(negedge clk);
    spill_vld = 1'b0;
    chk(fault == !ok, tag, 64'(fault), 64'(!ok));
    if (ok) for (int i = 0; i < (1 << code); i++) bm[mb + off + i] = d[8*i +: 8];
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_fill(input int off, input int code, input string tag);
    bit ok = acc_ok(off, code);
    logic [63:0] e = ok ? model_rd(off, code) : 64'h0;
    fill_vld = 1'b1; fill_off = 4'(off); fill_wcode = 2'(code);
    @(negedge clk);
    fill_vld = 1'b0;
    chk(fault == !ok, tag, 64'(fault), 64'(!ok));
    chk(fill_rvld == 1'b0, "R6 early", 64'(fill_rvld), 64'h0);
    @(negedge clk);
    chk(fill_rvld == ok, tag, 64'(fill_rvld), 64'(ok));
    if (ok) chk(fill_rdata == e, tag, fill_rdata, e);
  endtask

  task automatic do_ctl(input bit a, input int sz, input bit pu, input bit po,
                        input string tag);
    bit bad;
    if (int'(a) + int'(pu) + int'(po) > 1) bad = 1;
    else if (a)  bad = (sz > MAXF) || (mb + sz > MEMB);
    else if (pu) bad = (md == SDEP);
    else         bad = (md == 0);
    alloc_vld = a; alloc_size = 5'(sz); call_push = pu; ret_pop = po;
    @(negedge clk);
    alloc_vld = 1'b0; call_push = 1'b0; ret_pop = 1'b0;
    chk(fault == bad, tag, 64'(fault), 64'(bad));
    if (!bad) begin
      if (a) ms = sz;
      else if (pu) begin sb[md] = mb; ss[md] = ms; md++; mb = mb + ms; ms = 0; end
      else begin md--; mb = sb[md]; ms = ss[md]; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] oldv, newv;
    for (int i = 0; i < MEMB; i++) bm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(fault == 1'b0, "R1 fault", 64'(fault), 64'h0);
    chk(fill_rvld == 1'b0, "R1 rvld", 64'(fill_rvld), 64'h0);
    do_spill(0, 0, 64'h55, "R1 unallocated spill");
    do_fill(0, 0, "R1 unallocated fill");
    // R2: allocation limits
    do_ctl(1, 20, 0, 0, "R2 oversize");
    do_spill(0, 0, 64'h11, "R2 still empty");
    do_ctl(1, 16, 0, 0, "R2 alloc");
    do_fill(8, 3, "R1 zero contents");
    // R3 R4 R5: sweep every width code and offset
    for (int code = 0; code < 4; code++) begin
      for (int off = 0; off < MAXF; off++) begin
        do_spill(off, code, pat(off, code, 0), "R4 R5 spill sweep");
        do_fill(off, code, "R3 fill sweep");
      end
    end
    for (int code = 0; code < 4; code++)
      for (int off = 0; off < MAXF; off++) do_fill(off, code, "R3 readback");
    // R7: ordering against the write pipeline
    oldv = model_rd(8, 3);
    newv = 64'hDEADBEEF01234567;
    spill_vld = 1'b1; spill_off = 4'd8; spill_wcode = 2'd3; spill_data = newv;
    @(negedge clk);
    spill_vld = 1'b0;
    fill_vld = 1'b1; fill_off = 4'd8; fill_wcode = 2'd3;
    @(negedge clk);
    @(negedge clk);
    chk(fill_rvld && fill_rdata == oldv, "R7 fill +1", fill_rdata, oldv);
    for (int i = 0; i < 8; i++) bm[mb + 8 + i] = newv[8*i +: 8];
    @(negedge clk);
    fill_vld = 1'b0;
    chk(fill_rvld && fill_rdata == oldv, "R7 fill +2", fill_rdata, oldv);
    @(negedge clk);
    chk(fill_rvld && fill_rdata == newv, "R7 fill +3", fill_rdata, newv);
    @(negedge clk);
    // R8: stacking regions up to the limit
    for (int lvl = 1; lvl <= SDEP; lvl++) begin
      do_ctl(0, 0, 1, 0, "R8 push");
      do_spill(0, 3, pat(lvl, 3, lvl), "R8 fresh region");
      do_ctl(1, (lvl == SDEP) ? 1 : 16, 0, 0, "R2 R8 alloc");
      do_spill(0, 3, pat(lvl, 3, lvl), "R8 spill level");
      do_spill(8, 3, pat(lvl, 2, lvl), "R8 spill level");
    end
    do_ctl(1, 0, 0, 0, "R2 zero alloc");
    do_ctl(0, 0, 1, 0, "R8 push full");
    // R10: simultaneous control strobes
    do_ctl(0, 0, 1, 1, "R10 push+pop");
    do_ctl(1, 4, 0, 1, "R10 alloc+pop");
    do_fill(0, 3, "R10 state held");
    // R9: unwind and verify callers
    for (int lvl = SDEP; lvl >= 1; lvl--) begin
      do_ctl(0, 0, 0, 1, "R9 pop");
      do_fill(0, 3, "R9 caller data");
      do_fill(8, 3, "R9 caller data");
      do_fill(15, 0, "R9 caller size");
    end
    do_ctl(0, 0, 0, 1, "R9 pop empty");
    do_fill(8, 2, "R9 base frame");
    // R11: fault only for one cycle
    do_spill(3, 1, 64'h1, "R11 misaligned");
    chk(fault == 1'b0, "R11 pulse ends", 64'(fault), 64'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule